// File: doc/BRIEF.md
# Piecewise Gamma Curve Interpolator

This block maps each 8-bit colour code of a pixel stream onto a 10-bit drive level. It does this by straight-line interpolation between 26 programmable breakpoints. The breakpoints sit at fixed input codes that are spaced unevenly: close together near black and near white, and wide apart in the mid-tones. The block holds six curves, one per colour channel for each drive polarity. A per-pixel select picks the positive set or the negative set.

Curves arrive one byte per cycle on a small load port. A load is first checked for a strictly rising shape, and only then does it replace the curve in use. A curve that fails the check is thrown away, and its flag reports the failure. The pixel stream passes through a two-stage pipeline with valid/ready flow control on both sides.

Top module: `gamma_interp`

## Requirements
- R1: Out of reset every curve holds the linear default level(k) = floor(k*1023/255) at each breakpoint code k, all six `curve_ok` bits are 1, `out_valid` is 0 and `pix_ready` is 1.
- R2: A channel code equal to a breakpoint code (0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128, 160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254, 255) returns exactly the stored level of that point.
- R3: A code x between breakpoints xa < x < xb, with levels ya and yb, returns ya + floor((yb-ya)*(x-xa)/(xb-xa)).
- R4: After a `load_start` pulse, a load is 52 accepted `load_en` bytes: two per point, from the lowest code to the highest. The first byte of each pair carries level bits 9:8 in its bits 1:0, and its bits 7:2 are ignored. The second byte carries level bits 7:0.
- R5: `load_sel` encodes the curve: 0 red positive, 1 green positive, 2 blue positive, 3 red negative, 4 green negative, 5 blue negative. A `load_start` with `load_sel` 6 or 7 is ignored. `pix_neg`=0 selects the positive curves and 1 selects the negative ones. Each channel uses only its own colour's curves.
- R6: A load whose 26 levels rise strictly replaces the selected curve and sets its `curve_ok` bit. Both take effect on the clock edge after the edge that takes the last byte.
- R7: A load with any level equal to or below the level before it clears the selected `curve_ok` bit and leaves the curve in use unchanged.
- R8: An accepted pixel appears on the outputs two clock edges after acceptance. With `out_ready` held high, a new pixel is accepted on every cycle.
- R9: While `out_valid` is high and `out_ready` is low, the output data stays unchanged. No pixel is lost or duplicated under backpressure.
- R10: `load_en` bytes outside an open load (before any start, or after the 52nd byte) change no curve and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_start | input | 1 | Opens a curve load for `load_sel` |
| load_sel | input | 3 | Curve index for the load |
| load_en | input | 1 | Load byte strobe |
| load_byte | input | 8 | Load byte |
| curve_ok | output | 6 | Per-curve flag: last load rose strictly |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Block can accept a pixel |
| pix_neg | input | 1 | Polarity of this pixel (1 = negative curves) |
| pix_r | input | 8 | Red code |
| pix_g | input | 8 | Green code |
| pix_b | input | 8 | Blue code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_r | output | 10 | Red drive level |
| out_g | output | 10 | Green drive level |
| out_b | output | 10 | Blue drive level |

## Verification
Every one of the 256 codes is swept through all three channels, each channel through a different bijection of the sweep. This is done under both polarities, so breakpoint hits are separated from interpolated codes and no channel can borrow another channel's curve. The sweeps are repeated after loads that reach level 0 and level 1023, after loads that are rejected for a flat step or a falling final point, after stray bytes and an out-of-range select, and with pseudo-random stalls on `out_ready`. Together these separate a committed curve from a retained curve and a held output from a dropped or repeated pixel.

// File: rtl/gamma_interp_pkg.sv
package gamma_interp_pkg;

  localparam int NKNEE = 26;
  localparam int CODE_W = 8;

  // Input code of breakpoint i; neighbouring spacings are powers of two.
  function automatic logic [CODE_W-1:0] knee_at(input int i);
    logic [CODE_W-1:0] k;
    case (i)
      0: k = 8'd0;     1: k = 8'd1;     2: k = 8'd3;     3: k = 8'd5;
      4: k = 8'd7;     5: k = 8'd11;    6: k = 8'd15;    7: k = 8'd23;
      8: k = 8'd31;    9: k = 8'd47;   10: k = 8'd63;   11: k = 8'd95;
     12: k = 8'd127;  13: k = 8'd128;  14: k = 8'd160;  15: k = 8'd192;
     16: k = 8'd208;  17: k = 8'd224;  18: k = 8'd232;  19: k = 8'd240;
     20: k = 8'd244;  21: k = 8'd248;  22: k = 8'd250;  23: k = 8'd252;
     24: k = 8'd254;  default: k = 8'd255;
    endcase
    return k;
  endfunction

  // Straight-line default level for breakpoint i, full scale top_lvl.
  function automatic int lin_level(input int i, input int top_lvl);
    return int'(knee_at(i)) * top_lvl / 255;
  endfunction

endpackage

// File: rtl/gamma_curve_store.sv
module gamma_curve_store
  import gamma_interp_pkg::*;
#(
  parameter int OUT_W  = 10,
  parameter int NCURVE = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load_start,
  input  logic [$clog2(NCURVE)-1:0]              load_sel,
  input  logic                                   load_en,
  input  logic [7:0]                             load_byte,
  output logic [NCURVE-1:0][NKNEE-1:0][OUT_W-1:0] curves,
  output logic [NCURVE-1:0]                      curve_ok
);

  localparam int SEL_W  = $clog2(NCURVE);
  localparam int HI_W   = OUT_W - 8;
  localparam int NBYTES = 2 * NKNEE;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);
  localparam int TOP_LVL = (1 << OUT_W) - 1;

  logic                              act_q, act_n;
  logic [CNT_W-1:0]                  cnt_q, cnt_n;
  logic [SEL_W-1:0]                  sel_q, sel_n;
  logic                              bad_q, bad_n;
  logic                              pend_q, pend_n;
  logic [HI_W-1:0]                   hi_q, hi_n;
  logic [OUT_W-1:0]                  prev_q, prev_n;
  logic                              sh_we;
  logic [OUT_W-1:0]                  new_pt;
  logic [CNT_W-2:0]                  pt_idx;
  logic [NKNEE-1:0][OUT_W-1:0]       stage_q;
  logic [NCURVE-1:0][NKNEE-1:0][OUT_W-1:0] cv_q;
  logic [NCURVE-1:0]                 ok_q;

  assign new_pt = {hi_q, load_byte};
  assign pt_idx = cnt_q[CNT_W-1:1];

  always_comb begin
    act_n  = act_q;
    cnt_n  = cnt_q;
    sel_n  = sel_q;
    bad_n  = bad_q;
    hi_n   = hi_q;
    prev_n = prev_q;
    pend_n = 1'b0;
    sh_we  = 1'b0;
    if (load_start && (int'(load_sel) < NCURVE)) begin
      act_n = 1'b1;
      cnt_n = '0;
      sel_n = load_sel;
      bad_n = 1'b0;
    end else if (load_en && act_q) begin
      if (!cnt_q[0]) begin
        hi_n = load_byte[HI_W-1:0];
      end else begin
        sh_we  = 1'b1;
        prev_n = new_pt;
        if ((pt_idx != '0) && (new_pt <= prev_q)) bad_n = 1'b1;
      end
      if (cnt_q == LAST) begin
        act_n  = 1'b0;
        pend_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      bad_q  <= 1'b0;
      pend_q <= 1'b0;
      hi_q   <= '0;
      prev_q <= '0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      sel_q  <= sel_n;
      bad_q  <= bad_n;
      pend_q <= pend_n;
      hi_q   <= hi_n;
      prev_q <= prev_n;
    end
  end

  // Staging buffer: written point by point, needs no reset.
  always_ff @(posedge clk) begin
    if (sh_we) stage_q[pt_idx] <= new_pt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCURVE; c++) begin
        for (int i = 0; i < NKNEE; i++) begin
          cv_q[c][i] <= OUT_W'(lin_level(i, TOP_LVL));
        end
      end
      ok_q <= '1;
    end else if (pend_q) begin
      ok_q[sel_q] <= !bad_q;
      if (!bad_q) cv_q[sel_q] <= stage_q;
    end
  end

  assign curves   = cv_q;
  assign curve_ok = ok_q;

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !bad_q) |=> (curve_ok[$past(sel_q)] && (curves[$past(sel_q)] == $past(stage_q))));

  p_reject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bad_q) |=> !curve_ok[$past(sel_q)]);

  p_reject_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bad_q) |=> (curves == $past(curves)));

endmodule

// File: rtl/gamma_lane.sv
module gamma_lane
  import gamma_interp_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_en,
  input  logic                        mov_en,
  input  logic [CODE_W-1:0]           code,
  input  logic                        neg,
  input  logic [NKNEE-1:0][OUT_W-1:0] pos_cv,
  input  logic [NKNEE-1:0][OUT_W-1:0] neg_cv,
  output logic [OUT_W-1:0]            level
);

  localparam int OFF_W = 5;
  localparam int SH_W  = 3;
  localparam int SEG_W = $clog2(NKNEE);

  logic [NKNEE-1:0][OUT_W-1:0] cv;
  logic [SEG_W-1:0]            seg;
  logic [CODE_W-1:0]           x0, w, off_w;
  logic [SH_W-1:0]             sh_c;
  logic [OUT_W-1:0]            y0_c, dy_c;
  logic [OUT_W-1:0]            y0_q, dy_q;
  logic [OFF_W-1:0]            off_q;
  logic [SH_W-1:0]             sh_q;
  logic [OUT_W+OFF_W-1:0]      prod;
  logic [OUT_W-1:0]            lvl_n, lvl_q;

  // Stage 1: segment search and operand fetch.
  always_comb begin
    cv  = neg ? neg_cv : pos_cv;
    seg = '0;
    for (int i = 1; i < NKNEE - 1; i++) begin
      if (code >= knee_at(i)) seg = SEG_W'(i);
    end
    x0    = knee_at(int'(seg));
    w     = knee_at(int'(seg) + 1) - x0;
    off_w = code - x0;
    sh_c  = '0;
    for (int s = 0; s <= OFF_W; s++) begin
      if (w == CODE_W'(1 << s)) sh_c = SH_W'(s);
    end
    y0_c = cv[seg];
    dy_c = cv[SEG_W'(seg + 1'b1)] - cv[seg];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y0_q  <= '0;
      dy_q  <= '0;
      off_q <= '0;
      sh_q  <= '0;
    end else if (cap_en) begin
      y0_q  <= y0_c;
      dy_q  <= dy_c;
      off_q <= off_w[OFF_W-1:0];
      sh_q  <= sh_c;
    end
  end

  // Stage 2: scaled step added to the lower level.
  always_comb begin
    prod  = {{OFF_W{1'b0}}, dy_q} * {{OUT_W{1'b0}}, off_q};
    lvl_n = y0_q + OUT_W'(prod >> sh_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else if (mov_en) lvl_q <= lvl_n;
  end

  assign level = lvl_q;

  p_knee_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_en && (off_q == '0)) |=> (level == $past(y0_q)));

  p_in_segment_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mov_en |=> ((level >= $past(y0_q)) &&
                ({1'b0, level} <= ({1'b0, $past(y0_q)} + {1'b0, $past(dy_q)}))));

endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
  import gamma_interp_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [2:0]       load_sel,
  input  logic             load_en,
  input  logic [7:0]       load_byte,
  output logic [5:0]       curve_ok,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic             pix_neg,
  input  logic [7:0]       pix_r,
  input  logic [7:0]       pix_g,
  input  logic [7:0]       pix_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_g,
  output logic [OUT_W-1:0] out_b
);

  localparam int NCOL   = 3;
  localparam int NCURVE = 2 * NCOL;

  logic rst_s1_q, rst_s2_q;
  logic v1_q, v1_n, v2_q, v2_n;
  logic adv1, adv2, cap_en, mov_en;
  logic [NCURVE-1:0][NKNEE-1:0][OUT_W-1:0] curves;
  logic [NCOL-1:0][CODE_W-1:0] codes;
  logic [NCOL-1:0][OUT_W-1:0]  levels;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  gamma_curve_store #(.OUT_W(OUT_W), .NCURVE(NCURVE)) store_i (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .load_start (load_start),
    .load_sel   (load_sel),
    .load_en    (load_en),
    .load_byte  (load_byte),
    .curves     (curves),
    .curve_ok   (curve_ok)
  );

  always_comb begin
    adv2   = !v2_q || out_ready;
    adv1   = !v1_q || adv2;
    v2_n   = adv2 ? v1_q : v2_q;
    v1_n   = adv1 ? pix_valid : v1_q;
    cap_en = adv1 && pix_valid;
    mov_en = adv2 && v1_q;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_n;
      v2_q <= v2_n;
    end
  end

  assign codes = {pix_b, pix_g, pix_r};

  for (genvar c = 0; c < NCOL; c++) begin : g_lane
    gamma_lane #(.OUT_W(OUT_W)) lane_i (
      .clk    (clk),
      .rst_n  (rst_s2_q),
      .cap_en (cap_en),
      .mov_en (mov_en),
      .code   (codes[c]),
      .neg    (pix_neg),
      .pos_cv (curves[c]),
      .neg_cv (curves[c + NCOL]),
      .level  (levels[c])
    );
  end

  assign pix_ready = adv1;
  assign out_valid = v2_q;
  assign out_r     = levels[0];
  assign out_g     = levels[1];
  assign out_b     = levels[2];

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

endmodule

// File: tb/gamma_interp_tb_top.sv
module gamma_interp_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_start, load_en;
  logic [2:0]  load_sel;
  logic [7:0]  load_byte;
  logic [5:0]  curve_ok;
  logic        pix_valid, pix_ready, pix_neg;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        out_valid, out_ready;
  logic [9:0]  out_r, out_g, out_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gamma_interp dut_i (
    .clk(clk), .rst_n(rst_n),
    .load_start(load_start), .load_sel(load_sel), .load_en(load_en), .load_byte(load_byte),
    .curve_ok(curve_ok),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_neg(pix_neg),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int kx [26] = '{0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128,
                  160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254, 255};
  int mdl [6][26];
  bit mok [6];
  int n_chk = 0, n_fail = 0;
  logic [29:0] expq [$];
  string       tagq [$];
  bit          acc;
  bit          hold_pend = 0;
  logic [29:0] hold_val;
  logic [15:0] lf = 16'hACE1;
  int          stalls;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_knee(input int x);
    foreach (kx[i]) if (kx[i] == x) return 1;
    return 0;
  endfunction

  function automatic int ref_level(input int c, input int x);
    int s = 0;
    for (int i = 1; i < 25; i++) if (x >= kx[i]) s = i;
    return mdl[c][s] + (mdl[c][s+1] - mdl[c][s]) * (x - kx[s]) / (kx[s+1] - kx[s]);
  endfunction

  function automatic logic [5:0] ok_vec();
    logic [5:0] v;
    for (int c = 0; c < 6; c++) v[c] = mok[c];
    return v;
  endfunction

  task automatic tick();
    logic [29:0] e;
    int base;
    #1;
    acc = pix_valid && pix_ready;
    if (acc) begin
      base = pix_neg ? 3 : 0;
      e = {10'(ref_level(base + 2, int'(pix_b))), 10'(ref_level(base + 1, int'(pix_g))),
           10'(ref_level(base, int'(pix_r)))};
      expq.push_back(e);
      tagq.push_back(is_knee(int'(pix_r)) ? "R2" : "R3");
    end
    if (hold_pend) begin
      chk(out_valid && ({out_b, out_g, out_r} == hold_val), "R9 hold",
          {2'b0, out_b, out_g, out_r}, {2'b0, hold_val});
      hold_pend = 0;
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R9 extra output", {2'b0, out_b, out_g, out_r}, 0);
      else begin
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({out_b, out_g, out_r} == e, t, {2'b0, out_b, out_g, out_r}, {2'b0, e});
      end
    end else if (out_valid) begin
      hold_pend = 1;
      hold_val = {out_b, out_g, out_r};
    end
    @(negedge clk);
  endtask

  // Exhaustive sweep; channels use distinct bijections of the code.
  task automatic sweep(input bit neg, input bit bp);
    stalls = 0;
    for (int x = 0; x < 256; x++) begin
      do begin
        pix_valid = 1'b1;
        pix_neg   = neg;
        pix_r     = 8'(x);
        pix_g     = 8'(x * 7 + 3);
        pix_b     = 8'(255 - x);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        out_ready = bp ? lf[0] : 1'b1;
        tick();
        if (!acc) stalls++;
      end while (!acc);
    end
    pix_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 20 && expq.size() != 0; k++) tick();
    chk(expq.size() == 0, "R9 drain", expq.size(), 0);
  endtask

  task automatic load_curve(input int c, input int pts [26], input logic [5:0] junk);
    bit rise = 1;
    load_start = 1'b1;
    load_sel   = 3'(c);
    tick();
    load_start = 1'b0;
    for (int i = 0; i < 26; i++) begin
      load_en   = 1'b1;
      load_byte = {junk, 2'(pts[i] >> 8)};
      tick();
      load_byte = 8'(pts[i]);
      tick();
    end
    load_en = 1'b0;
    tick();
    tick();
    for (int i = 1; i < 26; i++) if (pts[i] <= pts[i-1]) rise = 0;
    mok[c] = rise;
    if (rise) for (int i = 0; i < 26; i++) mdl[c][i] = pts[i];
    chk(curve_ok == ok_vec(), rise ? "R6 flag" : "R7 flag", curve_ok, ok_vec());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int pa [26], pb [26], pc [26], pd [26];
    for (int c = 0; c < 6; c++) begin
      mok[c] = 1;
      for (int i = 0; i < 26; i++) mdl[c][i] = kx[i] * 1023 / 255;
    end
    for (int i = 0; i < 26; i++) begin
      pa[i] = i * 39 + (i % 3);
      pb[i] = i * i + 14 * i + 40;
      pd[i] = (i == 25) ? 1023 : i * 40;
    end
    rst_n = 1'b0; load_start = 0; load_en = 0; load_sel = 0; load_byte = 0;
    pix_valid = 0; pix_neg = 0; pix_r = 0; pix_g = 0; pix_b = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    chk(curve_ok == 6'h3f, "R1 flags", curve_ok, 6'h3f);
    chk(!out_valid && pix_ready, "R1 handshake", {out_valid, pix_ready}, 2'b01);
    @(negedge clk);
    sweep(0, 0);
    chk(stalls == 0, "R8 throughput", stalls, 0);
    sweep(1, 0);

    // R8 latency: out_valid two edges after acceptance
    pix_valid = 1; pix_neg = 0; pix_r = 8'd100; pix_g = 8'd200; pix_b = 8'd3; out_ready = 1;
    tick();
    pix_valid = 0;
    #1 chk(!out_valid, "R8 one edge", out_valid, 0);
    tick();
    #1 chk(out_valid, "R8 two edges", out_valid, 1);
    tick();

    // R4, R5, R6: good loads, junk in ignored high bits, extremes
    load_curve(1, pa, 6'h3f);
    load_curve(3, pb, 6'h15);
    load_curve(4, pd, 6'h00);
    sweep(0, 0);
    sweep(1, 0);

    // R7: flat step, then falling final point
    pc = pa; pc[13] = pc[12];
    load_curve(2, pc, 6'h00);
    pc = pa; pc[25] = pc[24] - 1;
    load_curve(3, pc, 6'h00);
    sweep(0, 0);
    sweep(1, 0);

    // R6 recovery after rejection
    load_curve(2, pb, 6'h2a);
    chk(curve_ok[2], "R6 recover", curve_ok[2], 1);

    // R10 stray bytes, R5 out-of-range select
    for (int k = 0; k < 10; k++) begin
      load_en = 1; load_byte = 8'(255 - k * 20); tick();
    end
    load_en = 0;
    load_start = 1; load_sel = 3'd6; tick(); load_start = 0;
    for (int k = 0; k < 52; k++) begin
      load_en = 1; load_byte = 8'h00; tick();
    end
    load_en = 0; tick(); tick();
    chk(curve_ok == ok_vec(), "R10 flags", curve_ok, ok_vec());
    sweep(0, 0);
    sweep(1, 0);

    // R9 backpressure
    sweep(0, 1);
    sweep(1, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule